// File: doc/BRIEF.md
# Response Drain Engine

This block is a bus master that empties a response out of a FIFO-style register window reached through a byte-wide memory-mapped bus. A one-cycle `start` pulse captures a maximum length and a mode flag. The engine then loops. It polls the status byte until the response is ready. It fetches a 16-bit burst count from the two bytes that sit above the status byte. It then reads that many bytes, or fewer if fewer remain, from the data register. Each byte goes out on a one-cycle valid/byte stream.

In header mode (`paramMode` low), the engine ends after the first burst that brings the total to at least six bytes. This lets a caller fetch just the fixed header of a response. In full mode it keeps going until the requested length has been read. Both waits are bounded by timeouts given in clock cycles.

- If the status poll runs out of time, the run ends with the last status byte as the error code.
- If the burst count stays zero for too long, it counts as a burst of zero and the engine goes back to polling status.

At the end of every run the engine pulses `doneP` for one cycle. In that cycle `byteCount` holds the number of bytes delivered and `errCode` holds the error code.

Top module: `rsp_drain_engine`

## Requirements
- R1: After reset, `busReq`, `outValid` and `doneP` are low, and `byteCount` and `errCode` are zero.
- R2: `start` captures `maxLen` and `paramMode` only when the engine is idle. A `start` pulse during a run has no effect on that run's bytes, count or error code.
- R3: Before each burst the engine reads address 0x18 until the returned byte has both bit 7 and bit 4 set. A bus request holds `busAddr` unchanged until `busAck`.
- R4: The burst count is fetched as a single-byte read at 0x19 (low byte), then a single-byte read at 0x1A (high byte). Address 0x18 is never read between those two reads. A zero count makes the engine fetch the pair again.
- R5: If the burst count is still zero once BURST_TMO cycles have passed since the status check succeeded, the burst counts as zero. No data byte is read and the engine returns to polling 0x18.
- R6: Each burst reads exactly min(remaining length, burst count) bytes from address 0x24.
- R7: Every byte read from 0x24 appears on `outByte` with `outValid` high for exactly one cycle, in read order.
- R8: With `paramMode` low, the run ends after the first burst in which the running total reaches 6 or more bytes.
- R9: With `paramMode` high, the run ends once `maxLen` bytes have been read.
- R10: If no ready status arrives within POLL_TMO cycles, the run ends. `errCode` holds the last status byte and `byteCount` holds the bytes delivered so far.
- R11: `doneP` is a one-cycle pulse. `byteCount` equals the number of `outValid` cycles in the run, and `errCode` is zero after a run that did not time out.
- R12: With `maxLen` zero, the run ends with a count of zero and no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| maxLen | input | LEN_W | Maximum number of bytes to read |
| paramMode | input | 1 | 1: read full length; 0: stop after header |
| busReq | output | 1 | Read request, held until acknowledged |
| busAddr | output | ADDR_W | Register address of the read |
| busAck | input | 1 | Read completion, one cycle |
| busData | input | 8 | Read data, valid with `busAck` |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Output byte |
| doneP | output | 1 | End-of-run pulse |
| byteCount | output | LEN_W | Bytes delivered in the run |
| errCode | output | 8 | Zero, or last status byte on poll timeout |

## Verification
A wrong remaining-length or burst counter shows up at the data port within a single burst. Too many or too few reads of 0x24 appear after a burst-count read, the output stream loses its byte order, or `byteCount` at `doneP` differs from the arithmetic expectation. A wrong sequencer state shows up as a pair read out of order, a status read inside a burst-count pair, or a missing or doubled `doneP`. A broken timer shows up only at the end of a stalled run, as a hang or a wrong `errCode`. The sweep covers every length from 0 to 13 against every burst size from 1 to 7 in both modes, so every split of the header across bursts is exercised.

// File: rtl/rsp_drain_pkg.sv
package rsp_drain_pkg;

  // Register offsets used by the engine
  localparam int STAT_OFS = 'h18;
  localparam int BLO_OFS  = 'h19;
  localparam int BHI_OFS  = 'h1A;
  localparam int DATA_OFS = 'h24;

  // Status byte bits that must both be set before a burst
  localparam int VALID_BIT = 7;
  localparam int AVAIL_BIT = 4;

  localparam int BURST_W = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOP, S_STAT, S_BLO, S_BHI, S_DATA, S_ENDB, S_FIN
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic clrTimer;
    logic capLo;
    logic capHi;
    logic takeByte;
    logic setErr;
  } ctlStrobe_t;

  // Flags from datapath to control
  typedef struct packed {
    logic statusOk;
    logic burstNz;
    logic burstLeftZ;
    logic remZ;
    logic headerDone;
    logic pollExp;
    logic burstExp;
  } dpFlags_t;

endpackage

// File: rtl/rsp_drain_dpath.sv
module rsp_drain_dpath
  import rsp_drain_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int HDR_LEN   = 6,
  parameter int POLL_TMO  = 100000,
  parameter int BURST_TMO = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       st,
  input  logic [7:0]       busData,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             paramMode,
  output dpFlags_t         flags,
  output logic             outValid,
  output logic [7:0]       outByte,
  output logic [LEN_W-1:0] byteCount,
  output logic [7:0]       errCode
);

  localparam int TMO_MAX = (POLL_TMO > BURST_TMO) ? POLL_TMO : BURST_TMO;
  localparam int TMR_W   = $clog2(TMO_MAX + 1) + 1;
  localparam logic [TMR_W-1:0] TMR_SAT = '1;

  logic [LEN_W-1:0]   lenReg;
  logic [LEN_W-1:0]   remLen;
  logic [LEN_W-1:0]   cnt;
  logic [7:0]         burstLo;
  logic [BURST_W-1:0] burstLeft;
  logic [TMR_W-1:0]   tmr;
  logic               modeReg;
  logic [7:0]         errReg;
  logic               outValidR;
  logic [7:0]         outByteR;

  // Length, count and mode registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      remLen  <= '0;
      cnt     <= '0;
      modeReg <= 1'b0;
    end else if (st.loadStart) begin
      lenReg  <= maxLen;
      remLen  <= maxLen;
      cnt     <= '0;
      modeReg <= paramMode;
    end else if (st.takeByte) begin
      remLen <= remLen - 1'b1;
      cnt    <= cnt + 1'b1;
    end
  end

  // Burst count capture and countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstLo   <= '0;
      burstLeft <= '0;
    end else begin
      if (st.capLo)
        burstLo <= busData;
      if (st.capHi)
        burstLeft <= {busData, burstLo};
      else if (st.takeByte)
        burstLeft <= burstLeft - 1'b1;
    end
  end

  // Shared cycle timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tmr <= '0;
    else if (st.clrTimer)
      tmr <= '0;
    else if (tmr != TMR_SAT)
      tmr <= tmr + 1'b1;
  end

  // Error code register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      errReg <= '0;
    else if (st.loadStart)
      errReg <= '0;
    else if (st.setErr)
      errReg <= busData;
  end

  // Output byte stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidR <= 1'b0;
      outByteR  <= '0;
    end else begin
      outValidR <= st.takeByte;
      if (st.takeByte)
        outByteR <= busData;
    end
  end

  always_comb begin
    flags.statusOk   = busData[VALID_BIT] & busData[AVAIL_BIT];
    flags.burstNz    = |{busData, burstLo};
    flags.burstLeftZ = (burstLeft == '0);
    flags.remZ       = (remLen == '0);
    flags.headerDone = !modeReg && (cnt >= LEN_W'(HDR_LEN));
    flags.pollExp    = (tmr >= TMR_W'(POLL_TMO));
    flags.burstExp   = (tmr >= TMR_W'(BURST_TMO));
  end

  assign outValid  = outValidR;
  assign outByte   = outByteR;
  assign byteCount = cnt;
  assign errCode   = errReg;

  // R6
  take_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.takeByte |-> (burstLeft != '0) && (remLen != '0));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lenReg);

  // R7
  out_follows_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.takeByte |=> outValid);

endmodule

// File: rtl/rsp_drain_ctrl.sv
module rsp_drain_ctrl
  import rsp_drain_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              busAck,
  input  dpFlags_t          flags,
  output ctlStrobe_t        st,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              doneP
);

  rdState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= S_IDLE;
    else
      state <= nextState;
  end

  always_comb begin
    nextState = state;
    st        = '0;
    busReq    = 1'b0;
    busAddr   = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.loadStart = 1'b1;
          nextState    = S_LOOP;
        end
      end
      S_LOOP: begin
        if (flags.remZ) begin
          nextState = S_FIN;
        end else begin
          st.clrTimer = 1'b1;
          nextState   = S_STAT;
        end
      end
      S_STAT: begin
        busReq  = 1'b1;
        busAddr = ADDR_W'(STAT_OFS);
        if (busAck) begin
          if (flags.statusOk) begin
            st.clrTimer = 1'b1;
            nextState   = S_BLO;
          end else if (flags.pollExp) begin
            st.setErr = 1'b1;
            nextState = S_FIN;
          end
        end
      end
      S_BLO: begin
        busReq  = 1'b1;
        busAddr = ADDR_W'(BLO_OFS);
        if (busAck) begin
          st.capLo  = 1'b1;
          nextState = S_BHI;
        end
      end
      S_BHI: begin
        busReq  = 1'b1;
        busAddr = ADDR_W'(BHI_OFS);
        if (busAck) begin
          st.capHi = 1'b1;
          if (flags.burstNz)
            nextState = S_DATA;
          else if (flags.burstExp)
            nextState = S_ENDB;
          else
            nextState = S_BLO;
        end
      end
      S_DATA: begin
        if (flags.burstLeftZ || flags.remZ) begin
          nextState = S_ENDB;
        end else begin
          busReq  = 1'b1;
          busAddr = ADDR_W'(DATA_OFS);
          if (busAck)
            st.takeByte = 1'b1;
        end
      end
      S_ENDB: begin
        nextState = flags.headerDone ? S_FIN : S_LOOP;
      end
      S_FIN: begin
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign doneP = (state == S_FIN);

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr));

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && (busAddr == ADDR_W'(BLO_OFS))
      |=> busReq && (busAddr == ADDR_W'(BHI_OFS)));

  // R11
  single_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !st.loadStart);

endmodule

// File: rtl/rsp_drain_engine.sv
module rsp_drain_engine
  import rsp_drain_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEN_W     = 11,
  parameter int HDR_LEN   = 6,
  parameter int POLL_TMO  = 100000,
  parameter int BURST_TMO = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic              paramMode,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic [7:0]        busData,
  output logic              outValid,
  output logic [7:0]        outByte,
  output logic              doneP,
  output logic [LEN_W-1:0]  byteCount,
  output logic [7:0]        errCode
);

  ctlStrobe_t strobes;
  dpFlags_t   flags;

  rsp_drain_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busAck  (busAck),
    .flags   (flags),
    .st      (strobes),
    .busReq  (busReq),
    .busAddr (busAddr),
    .doneP   (doneP)
  );

  rsp_drain_dpath #(
    .LEN_W     (LEN_W),
    .HDR_LEN   (HDR_LEN),
    .POLL_TMO  (POLL_TMO),
    .BURST_TMO (BURST_TMO)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .busData   (busData),
    .maxLen    (maxLen),
    .paramMode (paramMode),
    .flags     (flags),
    .outValid  (outValid),
    .outByte   (outByte),
    .byteCount (byteCount),
    .errCode   (errCode)
  );

endmodule

// File: tb/rsp_drain_engine_bench.sv
module rsp_drain_engine_bench;

  localparam int ADDR_W = 12;
  localparam int LEN_W  = 8;
  localparam int POLLT  = 40;
  localparam int BURSTT = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  maxLen = '0;
  logic              paramMode = 1'b0;
  logic              busReq;
  logic [ADDR_W-1:0] busAddr;
  logic              busAck = 1'b0;
  logic [7:0]        busData = '0;
  logic              outValid;
  logic [7:0]        outByte;
  logic              doneP;
  logic [LEN_W-1:0]  byteCount;
  logic [7:0]        errCode;

  always #4 clk = ~clk;

  rsp_drain_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HDR_LEN(6),
    .POLL_TMO(POLLT), .BURST_TMO(BURSTT)
  ) u_rsp_drain_engine (
    .clk(clk), .rstN(rstN), .start(start), .maxLen(maxLen),
    .paramMode(paramMode), .busReq(busReq), .busAddr(busAddr),
    .busAck(busAck), .busData(busData), .outValid(outValid),
    .outByte(outByte), .doneP(doneP), .byteCount(byteCount),
    .errCode(errCode)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  // bus model configuration
  int lat, notReadyLeft, readyLeft, zeroPairs, burstVal;
  logic [7:0] notReadyVal, stuckVal;
  int dataPtr, burstRem, viol, statAfterHi, waitCnt, runId;
  int lastAddr;
  // collector
  int gotN, byteErr, doneSeen;
  logic [LEN_W-1:0] doneCnt;
  logic [7:0] doneErr;

  function automatic logic [7:0] respByte(input int i, input int r);
    return 8'((i * 29) + (r * 7) + 3);
  endfunction

  function automatic int expCount(input int len, input int b, input bit mode);
    int c = 0;
    int rem = len;
    while (rem > 0) begin
      int n = (rem < b) ? rem : b;
      c += n;
      rem -= n;
      if (!mode && c >= 6) break;
    end
    return c;
  endfunction

  always @(negedge clk) begin
    if (busAck) begin
      busAck = 1'b0;
    end else if (busReq) begin
      if (waitCnt >= lat) begin
        waitCnt = 0;
        busAck = 1'b1;
        case (int'(busAddr))
          'h18: begin
            if (lastAddr == 'h19) viol++;
            if (lastAddr == 'h1A) statAfterHi++;
            if (notReadyLeft > 0) begin
              busData = notReadyVal; notReadyLeft--;
            end else if (readyLeft == 0) begin
              busData = stuckVal;
            end else begin
              busData = 8'hD0;
              if (readyLeft > 0) readyLeft--;
            end
          end
          'h19: busData = (zeroPairs > 0) ? 8'h00 : 8'(burstVal);
          'h1A: begin
            if (lastAddr != 'h19) viol++;
            if (zeroPairs > 0) begin
              busData = 8'h00; zeroPairs--;
            end else begin
              busData = 8'(burstVal >> 8);
              burstRem = burstVal;
            end
          end
          'h24: begin
            if (burstRem == 0) viol++; else burstRem--;
            busData = respByte(dataPtr, runId);
            dataPtr++;
          end
          default: viol++;
        endcase
        lastAddr = int'(busAddr);
      end else begin
        waitCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (outValid) begin
      if (outByte != respByte(gotN, runId)) byteErr++;
      gotN++;
    end
    if (doneP) begin
      doneSeen++;
      doneCnt = byteCount;
      doneErr = errCode;
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      finishRun();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (run %0d)", req, act, exp, runId);
    end
  endtask

  task automatic runOne(input int len, input int b, input bit mode,
                        input int expCnt, input int expErr, input bit midStart);
    runId++;
    dataPtr = 0; burstRem = 0; viol = 0; statAfterHi = 0; waitCnt = 0;
    lastAddr = 0; gotN = 0; byteErr = 0; doneSeen = 0; burstVal = b;
    @(negedge clk);
    maxLen = LEN_W'(len); paramMode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0; maxLen = '0; paramMode = ~mode;
    for (int i = 0; i < 3000 && doneSeen == 0; i++) begin
      if (midStart && i == 4) begin
        maxLen = LEN_W'(2); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(doneSeen == 1, "R11 done pulses", doneSeen, 1);
    chk(int'(doneCnt) == expCnt, "R6 R8 R9 byteCount", int'(doneCnt), expCnt);
    chk(gotN == expCnt, "R7 R11 outValid count", gotN, expCnt);
    chk(byteErr == 0, "R7 byte order", byteErr, 0);
    chk(int'(doneErr) == expErr, "R10 R11 errCode", int'(doneErr), expErr);
    chk(viol == 0, "R3 R4 R6 bus sequence", viol, 0);
  endtask

  initial begin
    runId = 0; lat = 0; notReadyLeft = 0; readyLeft = -1; zeroPairs = 0;
    notReadyVal = 8'h80; stuckVal = 8'h80; burstVal = 1;
    dataPtr = 0; burstRem = 0; viol = 0; statAfterHi = 0; waitCnt = 0;
    lastAddr = 0; gotN = 0; byteErr = 0; doneSeen = 0;
    doneCnt = '0; doneErr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busReq && !outValid && !doneP, "R1 idle outputs",
        int'({busReq, outValid, doneP}), 0);
    chk(byteCount == '0 && errCode == '0, "R1 count and error",
        int'(byteCount) + int'(errCode), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busReq && !doneP, "R1 quiet after reset", int'({busReq, doneP}), 0);

    // R12: zero length
    runOne(0, 3, 1'b1, 0, 0, 1'b0);
    chk(lastAddr == 0, "R12 no bus access", lastAddr, 0);

    // Sweep: R3 R4 R6 R7 R8 R9 R11
    for (int m = 0; m < 2; m++) begin
      for (int len = 0; len < 14; len++) begin
        for (int b = 1; b < 8; b++) begin
          lat = (len + b + m) % 3;
          notReadyLeft = (len + b) % 3;
          notReadyVal = (len % 2 != 0) ? 8'h80 : 8'h10;
          readyLeft = -1;
          zeroPairs = b % 2;
          runOne(len, b, m[0], expCount(len, b, m[0]), 0, 1'b0);
        end
      end
    end

    // R2: start pulse while busy is ignored
    lat = 1; notReadyLeft = 0; readyLeft = -1; zeroPairs = 0;
    runOne(10, 3, 1'b1, 10, 0, 1'b1);

    // R5: burst count stuck at zero; engine re-polls status, then status stalls
    lat = 0; readyLeft = 2; stuckVal = 8'h88; zeroPairs = 1000000;
    runOne(8, 4, 1'b1, 0, 'h88, 1'b0);
    chk(statAfterHi >= 1, "R5 status re-polled after burst timeout", statAfterHi, 1);
    zeroPairs = 0;

    // R10: status timeout after one burst keeps partial count
    lat = 1; readyLeft = 1; stuckVal = 8'h08;
    runOne(10, 4, 1'b1, 4, 'h08, 1'b0);

    // R8: header mode with large burst reads one whole burst
    readyLeft = -1;
    runOne(20, 10, 1'b0, 10, 0, 1'b0);

    finishRun();
  end

endmodule